// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block is the 64-bit control and status word that sits beside a floating-point unit. Every completed floating-point operation reports its exception conditions on a six-bit vector. The register ORs each report into a set of sticky flags that only software can clear, and it keeps a summary bit in the top position that shows whether any flag is up. The same word holds the controls software uses to tune exception handling: a trap-disable bit for inexact results, a trap-disable bit for underflow, and a bit that forces underflowed results to a true zero.

The block also keeps a two-bit dynamic rounding mode. An instruction that asks for dynamic rounding is given this field as its rounding mode. Any other instruction keeps the static mode it carries. The trap request and force-zero outputs are combinational from the report inputs and the stored controls, so the execution pipeline can act on them in the cycle the report arrives.

Software reads the whole word at any time and replaces it with a single write. The low 52 bits are reserved.

Top module: `fp_csr`

## Requirements
- R1: With no software write, no exception flag (bits 57..52) ever changes from 1 to 0.
- R2: When `excValid` is high, each set bit of `excFlags` sets its flag in the cycle after. The mapping is `excFlags[5]`→bit 57 (integer overflow), [4]→56 (inexact), [3]→55 (underflow), [2]→54 (overflow), [1]→53 (divide by zero), [0]→52 (invalid).
- R3: Bit 63 always reads as the OR of bits 57..52. The value written to bit 63 has no effect.
- R4: A write loads bits 62..52 from `swWrData` in the cycle after. If an exception report arrives in the same cycle as the write, the reported flags are ORed into the written flags.
- R5: `trapReq` is high in any cycle where `excValid` is high and a reported flag is not disabled. Only inexact can be disabled, by bit 62, and underflow, by bit 61 (see R6). When bit 62 is set, an inexact-only report gives no trap.
- R6: When bit 61 is set, an underflow-only report gives no trap.
- R7: `forceZero` is high when all of the following hold: `excValid` is high, underflow is reported, and bits 61 and 60 are both set. Bit 60 alone does not force a zero.
- R8: `rmSel` equals bits 59..58 when `dynReq` is high, and equals `staticMode` otherwise. The code is passed through unchanged: 00 chopped, 01 toward minus infinity, 10 to nearest, 11 toward plus infinity.
- R9: Bits 51..0 always read 0, whatever value is written to them.
- R10: After reset the whole word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 64 | Software write value |
| swRdData | output | 64 | Current register value |
| excValid | input | 1 | An exception report is present this cycle |
| excFlags | input | 6 | Reported exceptions, in the order given by R2 |
| dynReq | input | 1 | Instruction requests dynamic rounding |
| staticMode | input | 2 | Instruction's own rounding mode |
| rmSel | output | 2 | Rounding mode to use |
| trapReq | output | 1 | Reported exception needs a trap |
| forceZero | output | 1 | Replace the underflow result with all zeros |

## Verification
The bench covers the following corner cases. A write that clears the flags while a new exception arrives in the same cycle: a design that lets the write win loses that exception. A write that puts a 1 in the summary position while all flags are 0: a design that stores the summary bit reports a phantom exception. Reports that mix a disabled inexact or underflow with another condition: a design that applies the disable to the whole report suppresses a trap that must be raised. The underflow-to-zero bit with and without underflow disable: a design that checks only one of the two bits forces zeros it should not. All four dynamic rounding codes are checked against static requests, so a swapped or re-encoded field shows up on `rmSel`.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;
  localparam int DataW     = 64;
  localparam int FlagW     = 6;
  localparam int ModeW     = 2;
  localparam int SumBit    = 63;
  localparam int IneOffBit = 62;
  localparam int UnfOffBit = 61;
  localparam int UnfZeroBit = 60;
  localparam int DynLsb    = 58;
  localparam int FlagLsb   = 52;
  localparam int FlagMsb   = FlagLsb + FlagW - 1;

  // index of each condition in the reported flag vector
  localparam int FlInvalid = 0;
  localparam int FlDivZero = 1;
  localparam int FlOverflow = 2;
  localparam int FlUnderflow = 3;
  localparam int FlInexact = 4;
  localparam int FlIntOvf  = 5;

  typedef struct packed {
    logic             loadCtl;
    logic             loadFlags;
    logic [FlagW-1:0] setFlags;
  } csrStrobe_t;

  typedef struct packed {
    logic             inexactOff;
    logic             underflowOff;
    logic             underflowZero;
    logic [ModeW-1:0] dynMode;
  } csrCtl_t;
endpackage

// File: rtl/fp_csr_ctrl.sv
module fp_csr_ctrl
  import fp_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swWrEn,
  input  logic             excValid,
  input  logic [FlagW-1:0] excFlags,
  input  logic             dynReq,
  input  logic [ModeW-1:0] staticMode,
  input  csrCtl_t          ctlQ,
  output csrStrobe_t       strb,
  output logic [ModeW-1:0] rmSel,
  output logic             trapReq,
  output logic             forceZero
);
  logic [FlagW-1:0] trapEnable;
  logic [FlagW-1:0] reported;

  always_comb begin
    strb.loadCtl   = swWrEn;
    strb.loadFlags = swWrEn;
    strb.setFlags  = excValid ? excFlags : '0;
  end

  always_comb begin
    for (int i = 0; i < FlagW; i++) begin
      trapEnable[i] = 1'b1;
    end
    trapEnable[FlInexact]   = ~ctlQ.inexactOff;
    trapEnable[FlUnderflow] = ~ctlQ.underflowOff;
  end

  assign reported  = excValid ? excFlags : '0;
  assign trapReq   = |(reported & trapEnable);
  assign forceZero = reported[FlUnderflow] & ctlQ.underflowOff & ctlQ.underflowZero;
  assign rmSel     = dynReq ? ctlQ.dynMode : staticMode;

  AST_INEXACT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excFlags == FlagW'(1 << FlInexact) && ctlQ.inexactOff) |-> !trapReq); // R5
  AST_INVALID_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excFlags[FlInvalid]) |-> trapReq); // R5
  AST_UNDERFLOW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excFlags == FlagW'(1 << FlUnderflow) && ctlQ.underflowOff) |-> !trapReq); // R6
  AST_FORCE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    forceZero |-> (excValid && ctlQ.underflowOff && ctlQ.underflowZero)); // R7
endmodule

// File: rtl/fp_csr_dp.sv
module fp_csr_dp
  import fp_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  csrStrobe_t       strb,
  input  logic [DataW-1:0] swWrData,
  output csrCtl_t          ctlQ,
  output logic [DataW-1:0] rdData
);
  logic [FlagW-1:0] flagQ;
  logic [FlagW-1:0] flagD;
  csrCtl_t          ctlD;

  always_comb begin
    flagD = strb.loadFlags ? (swWrData[FlagMsb:FlagLsb] | strb.setFlags)
                           : (flagQ | strb.setFlags);
    ctlD = ctlQ;
    if (strb.loadCtl) begin
      ctlD.inexactOff    = swWrData[IneOffBit];
      ctlD.underflowOff  = swWrData[UnfOffBit];
      ctlD.underflowZero = swWrData[UnfZeroBit];
      ctlD.dynMode       = swWrData[DynLsb +: ModeW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagQ <= '0;
      ctlQ  <= '0;
    end else begin
      flagQ <= flagD;
      ctlQ  <= ctlD;
    end
  end

  generate
    for (genvar b = 0; b < FlagLsb; b++) begin : g_rsvd
      assign rdData[b] = 1'b0;
    end
  endgenerate
  assign rdData[FlagMsb:FlagLsb]     = flagQ;
  assign rdData[DynLsb +: ModeW]     = ctlQ.dynMode;
  assign rdData[UnfZeroBit]          = ctlQ.underflowZero;
  assign rdData[UnfOffBit]           = ctlQ.underflowOff;
  assign rdData[IneOffBit]           = ctlQ.inexactOff;
  assign rdData[SumBit]              = |flagQ;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadFlags |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R1
  AST_FLAGS_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb.setFlags) |=> ((flagQ & $past(strb.setFlags)) == $past(strb.setFlags))); // R2
  AST_CTL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadCtl |=> (rdData[IneOffBit:DynLsb] == $past(swWrData[IneOffBit:DynLsb]))); // R4
endmodule

// File: rtl/fp_csr.sv
module fp_csr
  import fp_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swWrEn,
  input  logic [DataW-1:0] swWrData,
  output logic [DataW-1:0] swRdData,
  input  logic             excValid,
  input  logic [FlagW-1:0] excFlags,
  input  logic             dynReq,
  input  logic [ModeW-1:0] staticMode,
  output logic [ModeW-1:0] rmSel,
  output logic             trapReq,
  output logic             forceZero
);
  csrStrobe_t strb;
  csrCtl_t    ctlQ;

  fp_csr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .swWrEn(swWrEn), .excValid(excValid),
    .excFlags(excFlags), .dynReq(dynReq), .staticMode(staticMode),
    .ctlQ(ctlQ), .strb(strb), .rmSel(rmSel), .trapReq(trapReq),
    .forceZero(forceZero)
  );

  fp_csr_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .swWrData(swWrData),
    .ctlQ(ctlQ), .rdData(swRdData)
  );
endmodule

// File: tb/tb_fp_csr.sv
module tb_fp_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swWrEn = 1'b0;
  logic [63:0] swWrData = '0;
  logic [63:0] swRdData;
  logic        excValid = 1'b0;
  logic [5:0]  excFlags = '0;
  logic        dynReq = 1'b0;
  logic [1:0]  staticMode = '0;
  logic [1:0]  rmSel;
  logic        trapReq;
  logic        forceZero;

  int tests = 0;
  int fails = 0;

  logic [5:0] mFlags = '0;
  logic [4:0] mCtl = '0;   // {ineOff, unfOff, unfZero, dyn[1:0]}

  always #10 clk = ~clk;

  fp_csr dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expRead();
    return {|mFlags, mCtl, mFlags, 52'd0};
  endfunction

  function automatic logic expTrap(input logic v, input logic [5:0] f);
    logic [5:0] en;
    en = {1'b1, ~mCtl[4], ~mCtl[3], 3'b111};
    return v & (|(f & en));
  endfunction

  task automatic step(input logic wr, input logic [63:0] wd, input logic ev,
                      input logic [5:0] ef, input logic dr, input logic [1:0] sm);
    logic [63:0] er;
    @(negedge clk);
    swWrEn = wr; swWrData = wd; excValid = ev; excFlags = ef;
    dynReq = dr; staticMode = sm;
    #1;
    er = expRead();
    chk("R3 summary bit", 64'(swRdData[63]), 64'(er[63]));
    chk("R4 control bits", 64'(swRdData[62:58]), 64'(er[62:58]));
    chk("R1/R2 flag bits", 64'(swRdData[57:52]), 64'(er[57:52]));
    chk("R9 reserved bits", 64'(swRdData[51:0]), 64'd0);
    chk("R5/R6 trapReq", 64'(trapReq), 64'(expTrap(ev, ef)));
    chk("R7 forceZero", 64'(forceZero), 64'(ev & ef[3] & mCtl[3] & mCtl[2]));
    chk("R8 rmSel", 64'(rmSel), 64'(dr ? mCtl[1:0] : sm));
    @(posedge clk);
    #1;
    if (wr) begin
      mCtl   = wd[62:58];
      mFlags = wd[57:52] | (ev ? ef : 6'd0);
    end else begin
      mFlags = mFlags | (ev ? ef : 6'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 reset value", swRdData, 64'd0);

    // R4 R9 R3: write all ones
    step(1'b1, {64{1'b1}}, 1'b0, 6'd0, 1'b0, 2'd0);
    // R4: clearing write with simultaneous inexact report keeps it
    step(1'b1, 64'd0, 1'b1, 6'b010000, 1'b0, 2'd0);
    // R1: idle cycles, flag must stay
    step(1'b0, 64'd0, 1'b0, 6'd0, 1'b0, 2'd1);
    step(1'b0, 64'd0, 1'b0, 6'd0, 1'b0, 2'd2);
    // R3: summary written as 1 with no flags
    step(1'b1, 64'h8000_0000_0000_0000, 1'b0, 6'd0, 1'b0, 2'd0);
    step(1'b0, 64'd0, 1'b0, 6'd0, 1'b0, 2'd0);
    // R5: inexact disabled, mixed with overflow
    step(1'b1, 64'(1) << 62, 1'b0, 6'd0, 1'b0, 2'd0);
    step(1'b0, 64'd0, 1'b1, 6'b010000, 1'b0, 2'd0);
    step(1'b0, 64'd0, 1'b1, 6'b010100, 1'b0, 2'd0);
    // R6 R7: underflow disabled without and with zero forcing
    step(1'b1, 64'(1) << 61, 1'b0, 6'd0, 1'b0, 2'd0);
    step(1'b0, 64'd0, 1'b1, 6'b001000, 1'b0, 2'd0);
    step(1'b1, 64'(1) << 60, 1'b0, 6'd0, 1'b0, 2'd0);
    step(1'b0, 64'd0, 1'b1, 6'b001000, 1'b0, 2'd0);
    step(1'b1, 64'(3) << 60, 1'b0, 6'd0, 1'b0, 2'd0);
    step(1'b0, 64'd0, 1'b1, 6'b001000, 1'b0, 2'd0);
    // R8: each dynamic code against a differing static code
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 64'(m) << 58, 1'b0, 6'd0, 1'b0, 2'd0);
      step(1'b0, 64'd0, 1'b0, 6'd0, 1'b1, 2'(~m));
      step(1'b0, 64'd0, 1'b0, 6'd0, 1'b0, 2'(~m));
    end

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) == 0, {$urandom, $urandom}, ($urandom % 2) == 1,
           6'($urandom & $urandom), ($urandom % 2) == 1, 2'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule